// File: doc/BRIEF.md
# Two-Wire Converter Control Slave

This block is the bus-facing control front end of a small data converter. It watches a two-wire serial bus (a clock line and a bidirectional data line) from the system clock. It recognises bus framing, answers its own 7-bit device address, and latches the control bytes that the bus master writes into two internal registers. One register holds the reference, clock-source and polarity fields. The other holds a channel configuration. The data line is only ever pulled low, through an active-high output enable, and the enable changes only while the bus clock is low.

The block also follows the master's switch into high-speed timing. When it sees the master code that announces high-speed transfers, it does not acknowledge. It then raises a high-speed flag, which stays up across repeated starts and drops on the next stop. For read transfers it only raises a one-cycle request pulse and releases the bus, because the read data path lives elsewhere.

Top module: `tw_adc_ctrl_slave`

## Requirements
- R1: A start is the data line falling while the bus clock is high, and a stop is the data line rising while the bus clock is high. After a stop the block answers nothing until the next start: an address byte sent without a start gets no acknowledge.
- R2: The first byte after a start holds the 7-bit address in bits 7:1 and the read/write flag in bit 0. On an address match the block pulls the data line low through the high phase of the ninth clock. Any other address, apart from the high-speed code, gets no acknowledge, and the block ignores the bus until the next start or stop.
- R3: A matching address with bit 0 = 1 (read) is acknowledged and gives exactly one single-cycle read_req pulse. The following bytes are neither acknowledged nor written.
- R4: An address-phase byte of the form 0000_1xxx is answered with a NOT-acknowledge. hs_mode then rises after the ninth clock.
- R5: A repeated start leaves hs_mode unchanged, and a stop always clears it.
- R6: In a write, a data byte with bit 7 = 1 loads ref_sel from bits 6:4, clk_ext from bit 3 and bipolar from bit 2. A data byte with bit 7 = 0 loads bits 6:0 into cfg_q.
- R7: A setup byte (bit 7 = 1) with bit 1 = 0 returns cfg_q to CFG_DEFAULT, while its own fields are still loaded. With bit 1 = 1, cfg_q keeps its value.
- R8: One or two data bytes, in either order, are each acknowledged and applied. Any further data byte in the same transfer is not acknowledged and changes no register.
- R9: After reset, hs_mode, sda_oe, read_req, ref_sel, clk_ext and bipolar are 0, and cfg_q equals CFG_DEFAULT.
- R10: sda_oe changes value only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low |
| hs_mode | output | 1 | High-speed timing mode flag |
| read_req | output | 1 | One-cycle pulse when a read is addressed |
| ref_sel | output | 3 | Reference selection field |
| clk_ext | output | 1 | 1 selects the external conversion clock |
| bipolar | output | 1 | 1 selects bipolar coding |
| cfg_q | output | 7 | Configuration register |

## Verification
The bench keeps the default device address and the two-stage synchronizer, and keeps the limit of two data bytes so that a rejected third byte can be reached. It overrides CFG_DEFAULT with the non-zero value 7'h2D. With that value, a configuration reset caused by a setup byte can be told apart from a zero write or from no change at all. A slow bus clock, several system cycles per phase, lets the bench sample the acknowledge slot in the middle of the high phase.

// File: rtl/tw_adc_pkg.sv
package tw_adc_pkg;
  localparam int CFG_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } bus_st_e;

  typedef struct packed {
    logic [2:0] ref_sel;
    logic       clk_ext;
    logic       bipolar;
  } setup_t;

  function automatic logic is_hs_code(input logic [7:0] b);
    return b[7:3] == 5'b00001;
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] a);
    return b[7:1] == a;
  endfunction

  function automatic logic is_setup_byte(input logic [7:0] b);
    return b[7];
  endfunction

  function automatic logic keeps_cfg(input logic [7:0] b);
    return b[1];
  endfunction

  function automatic setup_t decode_setup(input logic [7:0] b);
    setup_t s;
    s.ref_sel = b[6:4];
    s.clk_ext = b[3];
    s.bipolar = b[2];
    return s;
  endfunction
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_in;
          sda_pipe <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tw_byte_rx.sv
module tw_byte_rx #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            shift_en,
  input  logic            bit_in,
  output logic [BITS-1:0] data_q,
  output logic            full
);
  localparam int CW = $clog2(BITS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt    <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (shift_en) begin
      data_q <= {data_q[BITS-2:0], bit_in};
      cnt    <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CW'(BITS));

  // R2: the ninth clock never shifts in a data bit
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full && !clear |=> $stable(data_q));
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_adc_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 7'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  output setup_t           setup_q,
  output logic [CFG_W-1:0] cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      cfg_q   <= CFG_DEFAULT;
    end else if (wr_en) begin
      if (is_setup_byte(wr_byte)) begin
        setup_q <= decode_setup(wr_byte);
        if (!keeps_cfg(wr_byte)) cfg_q <= CFG_DEFAULT;
      end else begin
        cfg_q <= wr_byte[CFG_W-1:0];
      end
    end
  end

  assert_cfg_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_byte[7] |=> cfg_q == $past(wr_byte[6:0]));
  assert_setup_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_byte[7] |=> setup_q.ref_sel == $past(wr_byte[6:4]));
  assert_cfg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_byte[7] && !wr_byte[1] |=> cfg_q == CFG_DEFAULT);
  assert_cfg_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_byte[7] && wr_byte[1] |=> $stable(cfg_q));
endmodule

// File: rtl/tw_adc_ctrl_slave.sv
module tw_adc_ctrl_slave
  import tw_adc_pkg::*;
#(
  parameter logic [6:0]       SLAVE_ADDR     = 7'b1100100,
  parameter int               SYNC_STAGES    = 2,
  parameter int               MAX_DATA_BYTES = 2,
  parameter logic [CFG_W-1:0] CFG_DEFAULT    = 7'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic             hs_mode,
  output logic             read_req,
  output logic [2:0]       ref_sel,
  output logic             clk_ext,
  output logic             bipolar,
  output logic [CFG_W-1:0] cfg_q
);
  localparam int DCW = $clog2(MAX_DATA_BYTES + 1);

  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rx_byte;
  logic       rx_full, rx_clear, rx_shift;
  bus_st_e    state, after_ack;
  logic       in_ack, hs_arm, wr_pulse;
  logic [DCW-1:0] data_cnt;
  setup_t     setup_q;
  logic       ack_enter, ack_leave;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign ack_enter = scl_fall && !in_ack && rx_full &&
                     (state == ST_ADDR || state == ST_DATA);
  assign ack_leave = scl_fall && in_ack;
  assign rx_shift  = scl_rise && !in_ack && !rx_full &&
                     (state == ST_ADDR || state == ST_DATA);
  assign rx_clear  = start_det || ack_leave;

  tw_byte_rx #(.BITS(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(rx_clear), .shift_en(rx_shift),
    .bit_in(sda_s), .data_q(rx_byte), .full(rx_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      in_ack    <= 1'b0;
      sda_oe    <= 1'b0;
      hs_mode   <= 1'b0;
      hs_arm    <= 1'b0;
      read_req  <= 1'b0;
      wr_pulse  <= 1'b0;
      data_cnt  <= '0;
    end else begin
      read_req <= 1'b0;
      wr_pulse <= 1'b0;
      if (stop_det) begin
        state   <= ST_IDLE;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
        hs_arm  <= 1'b0;
        hs_mode <= 1'b0;
      end else if (start_det) begin
        state    <= ST_ADDR;
        in_ack   <= 1'b0;
        sda_oe   <= 1'b0;
        hs_arm   <= 1'b0;
        data_cnt <= '0;
      end else if (ack_enter) begin
        in_ack <= 1'b1;
        if (state == ST_ADDR) begin
          if (addr_hit(rx_byte, SLAVE_ADDR)) begin
            sda_oe    <= 1'b1;
            read_req  <= rx_byte[0];
            after_ack <= rx_byte[0] ? ST_SKIP : ST_DATA;
          end else if (is_hs_code(rx_byte)) begin
            hs_arm    <= 1'b1;
            after_ack <= ST_SKIP;
          end else begin
            after_ack <= ST_SKIP;
          end
        end else if (data_cnt < DCW'(MAX_DATA_BYTES)) begin
          sda_oe    <= 1'b1;
          wr_pulse  <= 1'b1;
          data_cnt  <= data_cnt + 1'b1;
          after_ack <= ST_DATA;
        end else begin
          after_ack <= ST_SKIP;
        end
      end else if (ack_leave) begin
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
        state  <= after_ack;
        if (hs_arm) hs_mode <= 1'b1;
        hs_arm <= 1'b0;
      end
    end
  end

  tw_reg_bank #(.CFG_DEFAULT(CFG_DEFAULT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_pulse), .wr_byte(rx_byte),
    .setup_q(setup_q), .cfg_q(cfg_q)
  );

  assign ref_sel = setup_q.ref_sel;
  assign clk_ext = setup_q.clk_ext;
  assign bipolar = setup_q.bipolar;

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe != $past(sda_oe) |-> !scl_s);
  assert_oe_ack_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> in_ack);
  assert_hs_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_arm |-> !sda_oe);
  assert_stop_fs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode);
  assert_sr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> hs_mode == $past(hs_mode));
  assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    read_req |=> !read_req);
  assert_byte_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> data_cnt <= DCW'(MAX_DATA_BYTES));
endmodule

// File: tb/sim_tw_adc_ctrl_slave.sv
module sim_tw_adc_ctrl_slave;
  localparam int CLK_PERIOD = 10;
  localparam int QW = 6;
  localparam int HW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1;
  logic sda_m = 1'b1;
  logic sda_in;
  logic sda_oe, hs_mode, read_req, clk_ext, bipolar;
  logic [2:0] ref_sel;
  logic [6:0] cfg_q;

  int checks = 0;
  int errors = 0;
  int rd_pulses = 0;
  int oe_viol = 0;
  logic oe_prev = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_in = sda_m & ~sda_oe;

  tw_adc_ctrl_slave #(.CFG_DEFAULT(7'h2D)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_oe(sda_oe), .hs_mode(hs_mode), .read_req(read_req),
    .ref_sel(ref_sel), .clk_ext(clk_ext), .bipolar(bipolar), .cfg_q(cfg_q)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (read_req) rd_pulses++;
      if (sda_oe !== oe_prev && scl_in) oe_viol++;
    end
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    @(posedge clk) sda_m <= 1'b1;
    wait_clk(QW);
    @(posedge clk) scl_in <= 1'b1;
    wait_clk(QW);
    @(posedge clk) sda_m <= 1'b0;
    wait_clk(QW);
    @(posedge clk) scl_in <= 1'b0;
    wait_clk(QW);
  endtask

  task automatic bus_stop();
    @(posedge clk) sda_m <= 1'b0;
    wait_clk(QW);
    @(posedge clk) scl_in <= 1'b1;
    wait_clk(HW);
    @(posedge clk) sda_m <= 1'b1;
    wait_clk(HW);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      @(posedge clk) sda_m <= b[i];
      wait_clk(QW);
      @(posedge clk) scl_in <= 1'b1;
      wait_clk(HW);
      @(posedge clk) scl_in <= 1'b0;
      wait_clk(QW);
    end
    @(posedge clk) sda_m <= 1'b1;
    wait_clk(QW);
    @(posedge clk) scl_in <= 1'b1;
    wait_clk(HW/2);
    @(negedge clk) acked = !sda_in;
    wait_clk(HW/2);
    @(posedge clk) scl_in <= 1'b0;
    wait_clk(QW);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 hs_mode", hs_mode, 0);
    chk("R9 sda_oe", sda_oe, 0);
    chk("R9 ref_sel", ref_sel, 0);
    chk("R9 clk_ext", clk_ext, 0);
    chk("R9 bipolar", bipolar, 0);
    chk("R9 cfg_q", cfg_q, 7'h2D);
    chk("R9 read_req", rd_pulses, 0);
  endtask

  task automatic t_setup_only();
    logic a;
    bus_start();
    send_byte(8'hC8, a); chk("R2 address ack", a, 1);
    send_byte(8'hDE, a); chk("R8 setup ack", a, 1);
    bus_stop();
    @(negedge clk);
    chk("R6 ref_sel", ref_sel, 5);
    chk("R6 clk_ext", clk_ext, 1);
    chk("R6 bipolar", bipolar, 1);
    chk("R7 cfg kept", cfg_q, 7'h2D);
  endtask

  task automatic t_cfg_then_setup_reset();
    logic a;
    bus_start();
    send_byte(8'hC8, a); chk("R2 address ack", a, 1);
    send_byte(8'h13, a); chk("R8 cfg ack", a, 1);
    chk("R6 cfg load", cfg_q, 7'h13);
    send_byte(8'h80, a); chk("R8 second ack", a, 1);
    bus_stop();
    @(negedge clk);
    chk("R7 cfg default", cfg_q, 7'h2D);
    chk("R7 setup fields ref", ref_sel, 0);
    chk("R7 setup fields clk", clk_ext, 0);
  endtask

  task automatic t_setup_then_cfg();
    logic a;
    bus_start();
    send_byte(8'hC8, a);
    send_byte(8'hA6, a); chk("R8 setup first ack", a, 1);
    send_byte(8'h55, a); chk("R8 cfg second ack", a, 1);
    bus_stop();
    @(negedge clk);
    chk("R6 ref_sel", ref_sel, 2);
    chk("R6 bipolar", bipolar, 1);
    chk("R6 cfg_q", cfg_q, 7'h55);
  endtask

  task automatic t_third_byte();
    logic a;
    bus_start();
    send_byte(8'hC8, a);
    send_byte(8'h11, a);
    send_byte(8'h12, a); chk("R8 second byte ack", a, 1);
    send_byte(8'h7F, a); chk("R8 third byte nack", a, 0);
    bus_stop();
    @(negedge clk);
    chk("R8 third byte ignored", cfg_q, 7'h12);
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send_byte(8'hCA, a); chk("R2 mismatch nack", a, 0);
    send_byte(8'h33, a); chk("R2 ignored byte nack", a, 0);
    bus_stop();
    @(negedge clk);
    chk("R2 cfg unchanged", cfg_q, 7'h12);
  endtask

  task automatic t_read();
    logic a;
    bus_start();
    send_byte(8'hC9, a); chk("R3 read address ack", a, 1);
    wait_clk(2);
    chk("R3 one read pulse", rd_pulses, 1);
    send_byte(8'h44, a); chk("R3 bus released", a, 0);
    bus_stop();
    @(negedge clk);
    chk("R3 no write", cfg_q, 7'h12);
  endtask

  task automatic t_no_start();
    logic a;
    send_byte(8'hC8, a); chk("R1 no ack without start", a, 0);
  endtask

  task automatic t_hs();
    logic a;
    bus_start();
    send_byte(8'h08, a); chk("R4 master code nack", a, 0);
    @(negedge clk) chk("R4 hs set", hs_mode, 1);
    bus_start();
    @(negedge clk) chk("R5 hs after Sr", hs_mode, 1);
    send_byte(8'hC8, a); chk("R2 ack in hs", a, 1);
    send_byte(8'h21, a);
    chk("R6 cfg in hs", cfg_q, 7'h21);
    bus_start();
    @(negedge clk) chk("R5 hs after second Sr", hs_mode, 1);
    bus_stop();
    @(negedge clk) chk("R5 stop clears hs", hs_mode, 0);
    bus_start();
    send_byte(8'h0F, a); chk("R4 other master code nack", a, 0);
    @(negedge clk) chk("R4 hs set again", hs_mode, 1);
    bus_stop();
    @(negedge clk) chk("R5 stop clears hs again", hs_mode, 0);
  endtask

  initial begin
    wait_clk(4);
    @(posedge clk) rst_n <= 1'b1;
    wait_clk(4);
    t_reset();
    t_setup_only();
    t_cfg_then_setup_reset();
    t_setup_then_cfg();
    t_third_byte();
    t_wrong_addr();
    t_read();
    t_no_start();
    t_hs();
    chk("R10 oe changes with clock low", oe_viol, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule